// File: doc/BRIEF.md
# Bitslip-aligned serial-to-parallel converter

This block turns a single-data-rate serial bit stream into parallel words. One bit is taken on every rising edge of a fast bit clock. A word of `WORD_W` bits (default 8) is presented on every rising edge of a word clock that runs at one `WORD_W`-th of the bit clock rate, with edges aligned to it. The bit received first within a word lands on the most significant output bit.

A surrounding link controller aligns the word stream by pulsing a slip request. Each accepted request moves the word boundary one bit later in the stream, like one step of a barrel shifter. After `WORD_W` accepted slips the boundary is back where it started. A qualifier output, `word_valid`, drops for a fixed settle window (`SETTLE_CYC` word cycles, default 2) after each accepted slip and after reset. A slip request that arrives while that window is open is discarded. The controller repeats the sequence "watch a known training word, slip, wait for `word_valid`" until the training word shows up unrotated.

Top module: `bitslip_deser`

## Requirements
- R1: Each rising `clk_ser` edge samples `ser_in`. The bit sampled first among the `WORD_W` bits of a word appears on `pword[WORD_W-1]`, and the bit sampled last appears on `pword[0]`.
- R2: Rising `clk_ser` edge number 8k coincides with rising `clk_word` edge number k. With s accepted slips since reset (taken mod 8), the word whose first bit was sampled on bit edge 8(k-2)+s is on `pword` after word edge k. `pword` changes only on `clk_word`.
- R3: `slip_req` is sampled on rising `clk_word`. A request seen while `word_valid` is high is accepted, and from the following word edge onward the window starts one bit later in the stream.
- R4: The slip position counts modulo `WORD_W`. Eight accepted slips from any position return the output to its previous alignment, and a step from position 7 goes to position 0.
- R5: After a slip accepted on word edge k, `word_valid` is low after edges k and k+1 and high again after edge k+2.
- R6: A `slip_req` sampled while `word_valid` is low is ignored. It does not move the slip position and does not lengthen the settle window.
- R7: `rst_n` is a synchronous, active-low reset on `clk_word`. While it is low, `pword` is all zeros, `word_valid` is low and the slip position returns to 0.
- R8: After the first word edge that samples `rst_n` high, `word_valid` stays low. It goes high after the next word edge, and data is correct from that edge on.
- R9: A stream that repeats the training word 8'hBC at bit phase p becomes 8'hBC on `pword` after exactly (p - position) mod 8 accepted slips, which is never more than 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ser | input | 1 | Bit clock; one serial bit per rising edge |
| clk_word | input | 1 | Word clock, one-eighth rate, edge-aligned to `clk_ser` |
| rst_n | input | 1 | Synchronous active-low reset, sampled on `clk_word` |
| ser_in | input | 1 | Serial data input |
| slip_req | input | 1 | One-word-cycle pulse requesting a one-bit boundary shift |
| pword | output | WORD_W | Parallel word, first-received bit in the MSB |
| word_valid | output | 1 | High when `pword` is settled and aligned |

## Verification
The bench builds the block with the defaults `WORD_W = 8` and `SETTLE_CYC = 2`. These settings let a short run reach every one of the eight slip positions, including the wrap from 7 back to 0 and a complete 8-slip rotation. The two-cycle settle window is long enough for the bench to place a second request inside it and show that the request is dropped. Training streams at bit phases 3, 7 and 2, a mid-run reset, and scoreboarded data bursts exercise both the exact output latency and the slip count needed for alignment.

// File: rtl/deser_pkg.sv
// deser_pkg
// Shared constants and helpers for the bitslip deserializer.
// Assumes: nothing beyond elaboration-time constants.
package deser_pkg;

    localparam int unsigned DEF_WORD_W     = 8;
    localparam int unsigned DEF_SETTLE_CYC = 2;

    // Step a slip position by one, wrapping at the word width.
    function automatic int unsigned wrap_step(int unsigned pos, int unsigned lim);
        return (pos + 1 >= lim) ? 0 : pos + 1;
    endfunction

endpackage

// File: rtl/deser_shift_in.sv
// deser_shift_in
// Bit-clock shift register. Each rising clk_ser edge moves the held bits
// one place toward the MSB and enters ser_in at the LSB, so the oldest of
// the last WORD_W bits sits in the MSB.
// Assumes: data needs no reset; the word clock reads this register on
// edges that coincide with bit-clock edges.
module deser_shift_in #(
    parameter int unsigned WORD_W = deser_pkg::DEF_WORD_W
) (
    input  logic              clk_ser,
    input  logic              ser_in,
    output logic [WORD_W-1:0] shreg
);

    // Enter one serial bit per bit-clock edge, oldest bit toward the MSB.
    always_ff @(posedge clk_ser) begin
        shreg <= {shreg[WORD_W-2:0], ser_in};
    end

endmodule

// File: rtl/deser_slip_ctrl.sv
// deser_slip_ctrl
// Word-clock control: holds the slip position, accepts slip requests only
// while the output is qualified, and times the settle window that keeps
// word_valid low after a slip or a reset.
// Assumes: SETTLE_CYC >= 1; rst_n is synchronous to clk_word.
module deser_slip_ctrl #(
    parameter int unsigned WORD_W     = deser_pkg::DEF_WORD_W,
    parameter int unsigned SETTLE_CYC = deser_pkg::DEF_SETTLE_CYC,
    localparam int unsigned OFF_W     = (WORD_W > 1) ? $clog2(WORD_W) : 1,
    localparam int unsigned CNT_W     = $clog2(SETTLE_CYC + 1)
) (
    input  logic             clk_word,
    input  logic             rst_n,
    input  logic             slip_req,
    output logic [OFF_W-1:0] slip_pos,
    output logic             word_valid
);

    logic [CNT_W-1:0] settle_q;
    logic             take_slip;

    // A request counts only when the output was qualified before this edge.
    assign take_slip = slip_req & word_valid;

    // Update slip position, settle countdown and output qualifier.
    always_ff @(posedge clk_word) begin
        if (!rst_n) begin
            slip_pos   <= '0;
            settle_q   <= CNT_W'(SETTLE_CYC);
            word_valid <= 1'b0;
        end else if (take_slip) begin
            slip_pos   <= OFF_W'(deser_pkg::wrap_step(32'(slip_pos), WORD_W));
            settle_q   <= CNT_W'(SETTLE_CYC);
            word_valid <= 1'b0;
        end else if (settle_q != '0) begin
            settle_q   <= settle_q - CNT_W'(1);
            word_valid <= (settle_q == CNT_W'(1));
        end else begin
            word_valid <= 1'b1;
        end
    end

endmodule

// File: rtl/deser_window.sv
// deser_window
// Word-clock barrel selector. It keeps the previous word next to the fresh
// one and picks a WORD_W-bit window that starts slip_pos bits after the
// previous word's first bit. The chosen window is registered as the output.
// Assumes: the fresh word is stable at each clk_word edge; history needs
// no reset; only the output register is cleared.
module deser_window #(
    parameter int unsigned WORD_W = deser_pkg::DEF_WORD_W,
    localparam int unsigned OFF_W = (WORD_W > 1) ? $clog2(WORD_W) : 1,
    localparam int unsigned SH_W  = OFF_W + 1
) (
    input  logic              clk_word,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] fresh,
    input  logic [OFF_W-1:0]  slip_pos,
    output logic [WORD_W-1:0] pword
);

    logic [WORD_W-1:0]   prev_q;
    logic [2*WORD_W-1:0] joined;
    logic [SH_W-1:0]     amt;
    logic [WORD_W-1:0]   pick;

    // Keep the word captured on the previous word-clock edge.
    always_ff @(posedge clk_word) begin
        prev_q <= fresh;
    end

    // Join history and fresh word, then shift so the window lands at the LSBs.
    always_comb begin
        joined = {prev_q, fresh};
        amt    = SH_W'(WORD_W) - SH_W'(slip_pos);
        pick   = WORD_W'(joined >> amt);
    end

    // Register the selected window; force zeros during reset.
    always_ff @(posedge clk_word) begin
        if (!rst_n) begin
            pword <= '0;
        end else begin
            pword <= pick;
        end
    end

endmodule

// File: rtl/bitslip_deser.sv
// bitslip_deser
// Single-data-rate serial-to-parallel converter with bitslip alignment.
// The bit-clock shifter gathers serial bits, and the word-clock selector
// picks a window whose start the slip controller moves one bit per
// accepted request. word_valid qualifies the output.
// Assumes: clk_word runs at 1/WORD_W of clk_ser with coincident rising
// edges (both derived from one source); slip_req is a one-word-cycle pulse.
module bitslip_deser #(
    parameter int unsigned WORD_W     = deser_pkg::DEF_WORD_W,
    parameter int unsigned SETTLE_CYC = deser_pkg::DEF_SETTLE_CYC
) (
    input  logic              clk_ser,
    input  logic              clk_word,
    input  logic              rst_n,
    input  logic              ser_in,
    input  logic              slip_req,
    output logic [WORD_W-1:0] pword,
    output logic              word_valid
);

    localparam int unsigned OFF_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

    logic [WORD_W-1:0] shreg;
    logic [OFF_W-1:0]  slip_pos;

    deser_shift_in #(.WORD_W(WORD_W)) u_shift (
        .clk_ser (clk_ser),
        .ser_in  (ser_in),
        .shreg   (shreg)
    );

    deser_slip_ctrl #(.WORD_W(WORD_W), .SETTLE_CYC(SETTLE_CYC)) u_ctrl (
        .clk_word   (clk_word),
        .rst_n      (rst_n),
        .slip_req   (slip_req),
        .slip_pos   (slip_pos),
        .word_valid (word_valid)
    );

    deser_window #(.WORD_W(WORD_W)) u_win (
        .clk_word (clk_word),
        .rst_n    (rst_n),
        .fresh    (shreg),
        .slip_pos (slip_pos),
        .pword    (pword)
    );

endmodule

// File: rtl/deser_checker.sv
// deser_checker
// Temporal properties for bitslip_deser, attached by bind. It watches the
// ports plus the slip position passed from the controller to the selector.
// Assumes: SETTLE_CYC >= 1.
module deser_checker #(
    parameter int unsigned WORD_W     = deser_pkg::DEF_WORD_W,
    parameter int unsigned SETTLE_CYC = deser_pkg::DEF_SETTLE_CYC,
    localparam int unsigned OFF_W     = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
    input logic              clk_word,
    input logic              rst_n,
    input logic              slip_req,
    input logic              word_valid,
    input logic [OFF_W-1:0]  slip_pos,
    input logic [WORD_W-1:0] pword
);

    logic [31:0] low_run;

    // Count consecutive word cycles with the qualifier low (saturating).
    always_ff @(posedge clk_word) begin
        if (!rst_n || word_valid) begin
            low_run <= '0;
        end else if (low_run < SETTLE_CYC) begin
            low_run <= low_run + 32'd1;
        end
    end

    // R7: reset clears output, qualifier and slip position.
    p_reset_clear_r7: assert property (@(posedge clk_word)
        !rst_n |=> (pword == '0 && !word_valid && slip_pos == '0));

    // R3, R4: an accepted slip advances the position by one, wrapping.
    p_slip_step_r3: assert property (@(posedge clk_word) disable iff (!rst_n)
        (slip_req && word_valid) |=>
        (slip_pos == (($past(slip_pos) == OFF_W'(WORD_W - 1)) ? '0 : $past(slip_pos) + 1'b1)));

    // R6: a request during the settle window leaves the position alone.
    p_slip_ignored_r6: assert property (@(posedge clk_word) disable iff (!rst_n)
        (slip_req && !word_valid) |=> $stable(slip_pos));

    // R5: an accepted slip drops the qualifier on the next cycle.
    p_valid_drop_r5: assert property (@(posedge clk_word) disable iff (!rst_n)
        (slip_req && word_valid) |=> !word_valid);

    // R5: the qualifier returns only after the full settle window.
    p_settle_len_r5: assert property (@(posedge clk_word) disable iff (!rst_n)
        $rose(word_valid) |-> (low_run >= SETTLE_CYC));

    // R8: the qualifier is still low one cycle after reset release.
    p_release_low_r8: assert property (@(posedge clk_word) disable iff (!rst_n)
        $rose(rst_n) |=> !word_valid);

endmodule

bind bitslip_deser deser_checker #(
    .WORD_W     (WORD_W),
    .SETTLE_CYC (SETTLE_CYC)
) u_chk (
    .clk_word   (clk_word),
    .rst_n      (rst_n),
    .slip_req   (slip_req),
    .word_valid (word_valid),
    .slip_pos   (slip_pos),
    .pword      (pword)
);

// File: tb/bitslip_deser_tb_top.sv
module bitslip_deser_tb_top;

    localparam logic [7:0] TRAIN = 8'hBC;

    logic       clk_f = 1'b0;
    logic       clk_d = 1'b0;
    logic       rst_n = 1'b0;
    logic       sdin  = 1'b0;
    logic       slip  = 1'b0;
    logic [7:0] pword;
    logic       valid;

    int fe      = -1;   // index of the latest rising bit-clock edge
    int ph      = 0;    // bit phase of the transmitted stream
    int o_tb    = 0;    // bench model of the slip position
    int data_on = 0;
    int dj0     = 0;
    int dn      = 0;
    int checks  = 0;
    int errors  = 0;

    typedef struct { int k; logic [7:0] b; } exp_t;
    exp_t sb_q[$];

    bitslip_deser dut_i (
        .clk_ser    (clk_f),
        .clk_word   (clk_d),
        .rst_n      (rst_n),
        .ser_in     (sdin),
        .slip_req   (slip),
        .pword      (pword),
        .word_valid (valid)
    );

    // 125 MHz bit clock; word clock rises on every eighth bit edge.
    initial begin
        forever begin
            #4;
            fe = fe + 1;
            clk_f = 1'b1;
            if (fe % 8 == 0) clk_d = 1'b1;
            else if (fe % 8 == 4) clk_d = 1'b0;
            #4;
            clk_f = 1'b0;
        end
    end

    function automatic logic [7:0] rotl8(logic [7:0] v, int n);
        return (v << n) | (v >> (8 - n));
    endfunction

    function automatic logic [7:0] data_byte(int j);
        logic [31:0] t;
        t = j * 73 + 29;
        return t[7:0] ^ t[10:3];
    endfunction

    // Serial bit for rising bit edge m, MSB of each byte first.
    function automatic logic bit_at(int m);
        int rel;
        int j;
        int p;
        logic [7:0] by;
        rel = m - ph;
        if (rel < 0) return 1'b0;
        j  = rel / 8;
        p  = rel % 8;
        by = (data_on != 0 && j >= dj0 && j < dj0 + dn) ? data_byte(j) : TRAIN;
        return by[7 - p];
    endfunction

    // Serial driver: sets the bit for the next rising bit edge.
    initial begin
        forever begin
            @(negedge clk_f);
            sdin = bit_at(fe + 1);
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops scoreboard entries as their word edge comes up.
    initial begin
        forever begin
            int k;
            @(negedge clk_d);
            k = fe / 8;
            while (sb_q.size() > 0 && sb_q[0].k < k) begin
                exp_t m;
                m = sb_q.pop_front();
                chk(1'b0, "R2", "missed word edge", 32'(k), 32'(m.k));
            end
            if (sb_q.size() > 0 && sb_q[0].k == k) begin
                exp_t e;
                e = sb_q.pop_front();
                chk(pword == e.b, "R2", "data word", 32'(pword), 32'(e.b));
                chk(valid == 1'b1, "R2", "valid during data", 32'(valid), 32'd1);
            end
        end
    end

    // Driver: queues expected words for a burst and sends it (needs o_tb == ph).
    task automatic data_burst(input int n);
        int j0;
        j0 = (fe - ph) / 8 + 3;
        for (int j = j0; j < j0 + n; j++) begin
            exp_t e;
            e.k = j + 2;
            e.b = data_byte(j);
            sb_q.push_back(e);
        end
        dj0 = j0;
        dn  = n;
        data_on = 1;
        for (int w = 0; w < n + 20 && sb_q.size() > 0; w++) @(negedge clk_d);
        chk(sb_q.size() == 0, "R2", "words left in scoreboard", 32'(sb_q.size()), 32'd0);
        data_on = 0;
    endtask

    // One slip pulse, then the settle window is checked (R5).
    task automatic slip_settle();
        @(negedge clk_d); @(negedge clk_f); slip = 1'b1;
        @(negedge clk_d); @(negedge clk_f); slip = 1'b0;
        chk(!valid, "R5", "valid after slip edge", 32'(valid), 32'd0);
        @(negedge clk_d);
        chk(!valid, "R5", "valid one edge later", 32'(valid), 32'd0);
        @(negedge clk_d);
        chk(valid, "R5", "valid two edges later", 32'(valid), 32'd1);
        o_tb = (o_tb + 1) % 8;
    endtask

    task automatic wait_valid();
        for (int w = 0; w < 10 && !valid; w++) @(negedge clk_d);
    endtask

    // Align to a training stream at a new phase, counting slips (R9, R3).
    task automatic align(input int new_ph);
        int need;
        int cnt;
        ph = new_ph;
        repeat (4) @(negedge clk_d);
        need = (new_ph - o_tb) & 7;
        cnt = 0;
        for (int it = 0; it < 9; it++) begin
            wait_valid();
            if (pword == TRAIN) break;
            chk(pword == rotl8(TRAIN, (o_tb - ph) & 7), "R3", "rotated word",
                32'(pword), 32'(rotl8(TRAIN, (o_tb - ph) & 7)));
            slip_settle();
            cnt++;
        end
        chk(pword == TRAIN, "R9", "aligned word", 32'(pword), 32'(TRAIN));
        chk(cnt == need && cnt <= 7, "R9", "slips needed", 32'(cnt), 32'(need));
    endtask

    // Apply reset mid-cycle and check the release timing (R7, R8).
    task automatic reset_cycle(input int hold);
        @(negedge clk_d); @(negedge clk_f); rst_n = 1'b0;
        repeat (hold) @(negedge clk_d);
        chk(pword == 8'h00, "R7", "pword in reset", 32'(pword), 32'd0);
        chk(!valid, "R7", "valid in reset", 32'(valid), 32'd0);
        @(negedge clk_f); rst_n = 1'b1;
        @(negedge clk_d);
        chk(!valid, "R8", "valid after release edge", 32'(valid), 32'd0);
        @(negedge clk_d);
        chk(valid, "R8", "valid after second edge", 32'(valid), 32'd1);
        o_tb = 0;
        chk(pword == rotl8(TRAIN, (0 - ph) & 7), "R7", "slip position cleared",
            32'(pword), 32'(rotl8(TRAIN, (0 - ph) & 7)));
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk_f);
        errors++;
        $display("FAIL R9 watchdog: actual %0d cycles expected completion", 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // Initial reset, stream at phase 0 (R7, R8, R1).
        repeat (5) @(negedge clk_d);
        chk(pword == 8'h00, "R7", "pword held in reset", 32'(pword), 32'd0);
        chk(!valid, "R7", "valid held in reset", 32'(valid), 32'd0);
        @(negedge clk_f); rst_n = 1'b1;
        @(negedge clk_d);
        chk(!valid, "R8", "valid after first edge", 32'(valid), 32'd0);
        @(negedge clk_d);
        chk(valid, "R8", "valid after second edge", 32'(valid), 32'd1);
        chk(pword == TRAIN, "R1", "MSB-first word at phase 0", 32'(pword), 32'(TRAIN));

        // Alignment at several phases, with scoreboarded data (R9, R3, R2).
        align(3);
        data_burst(20);
        align(7);
        data_burst(12);
        align(2);   // from position 7 this wraps through 0 (R4)

        // Full rotation: eight slips return the alignment (R4).
        for (int s = 0; s < 8; s++) begin
            slip_settle();
            chk(pword == rotl8(TRAIN, (o_tb - ph) & 7), "R4", "rotation step",
                32'(pword), 32'(rotl8(TRAIN, (o_tb - ph) & 7)));
        end
        chk(pword == TRAIN, "R4", "back to aligned after 8 slips", 32'(pword), 32'(TRAIN));

        // Request inside the settle window is dropped (R6).
        @(negedge clk_d); @(negedge clk_f); slip = 1'b1;
        @(negedge clk_d); @(negedge clk_f); slip = 1'b0;
        o_tb = (o_tb + 1) % 8;
        @(negedge clk_d); @(negedge clk_f); slip = 1'b1;
        @(negedge clk_d);
        chk(valid, "R6", "settle not extended", 32'(valid), 32'd1);
        @(negedge clk_f); slip = 1'b0;
        repeat (2) @(negedge clk_d);
        wait_valid();
        chk(pword == rotl8(TRAIN, (o_tb - ph) & 7), "R6", "only one step taken",
            32'(pword), 32'(rotl8(TRAIN, (o_tb - ph) & 7)));

        // Mid-run reset clears the slip position, then realign (R7, R8, R9).
        reset_cycle(3);
        align(2);
        align(0);
        data_burst(16);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule